// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator Channel

This block produces one pulse-width modulated output from a fast reference clock. A 4-bit code chooses how far the reference is divided before it reaches the cycle counter. The code is not linear: ten codes map to fixed dividers between 120 and 72000, one code passes the reference through undivided, and five codes are reserved and stop the counter. Software reaches the block through a small register bus. One control word and one word that packs the cycle length and the pulse width sit on this bus.

Three control bits run the channel: an enable, an output polarity, and a tick gate. A new division code is only accepted while the gate is off. Software therefore turns the gate off, writes the code, and turns the gate on again. A new cycle length or pulse width written while the channel runs takes effect at the next cycle boundary, so no pulse is ever cut short.

Top module: `pwm_prescaled_channel`

## Requirements
- R1: After reset the control word reads 0x02, the timing word reads 0, and `pwm_o` is 0.
- R2: Address 0 is the control word, with bit 0 = enable, bit 1 = active level (1 = active high), bit 2 = tick gate, bit 3 = 0, and bits [7:4] = division code. Address 1 is the timing word, with bits [31:16] = cycle length minus one (P) and bits [15:0] = pulse width (D). A read returns the word on `bus_rdata` one clock after `bus_re`.
- R3: A write to the control word changes the division code only when the tick gate is already 0 before that write. A code written while the gate is 1 is ignored, and the old code reads back.
- R4: Division codes map to dividers as follows: 0→120, 1→180, 2→240, 3→360, 4→480, 8→12000, 9→24000, 10→36000, 11→48000, 12→72000, 15→1. Code 15 advances the counter on every clock.
- R5: Codes 5, 6, 7, 13 and 14 are reserved. With a reserved code the counter does not advance and `pwm_o` stays at the inactive level.
- R6: While the channel runs, each cycle lasts P+1 ticks. The output is active for the first D ticks of the cycle and inactive for the rest.
- R7: D = 0 gives a constant inactive output. D > P gives a constant active output.
- R8: When the active-level bit is 1, the active level is high. When it is 0, the active level is low, so the output is inverted.
- R9: A timing word written while the channel runs takes effect at the end of the current cycle. The pulse in progress keeps its old width.
- R10: When the enable bit is 0 or the tick gate is 0, the counter is held at zero and `pwm_o` rests at the inactive level. When the channel is enabled again, a new cycle starts at once with the active phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_o | output | 1 | Modulated output |

## Verification
The modulator is driven with a short cycle and a narrow pulse in both polarities. This separates the cycle length from the pulse width and shows the polarity bit acting on the output. Pulse widths of zero and wider than the cycle check that the output holds constant at the two ends. Several divider codes check that the pulse widths scale by the right factor, and a reserved code checks that the counter stops. A timing word written during a pulse checks that the change waits for the cycle boundary. The gate sequence written out of order checks that a code written with the gate on is ignored.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DIV_W = 17;

  // divider for each 4-bit code; 0 marks a reserved code
  function automatic logic [DIV_W-1:0] div_of(input logic [3:0] code);
    case (code)
      4'h0: div_of = DIV_W'(120);
      4'h1: div_of = DIV_W'(180);
      4'h2: div_of = DIV_W'(240);
      4'h3: div_of = DIV_W'(360);
      4'h4: div_of = DIV_W'(480);
      4'h8: div_of = DIV_W'(12000);
      4'h9: div_of = DIV_W'(24000);
      4'hA: div_of = DIV_W'(36000);
      4'hB: div_of = DIV_W'(48000);
      4'hC: div_of = DIV_W'(72000);
      4'hF: div_of = DIV_W'(1);
      default: div_of = '0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              act_high,
  output logic              gate,
  output logic [3:0]        code,
  output logic [CNT_W-1:0]  prd,
  output logic [CNT_W-1:0]  duty
);
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      act_high <= 1'b1;
      gate     <= 1'b0;
      code     <= 4'h0;
      prd      <= '0;
      duty     <= '0;
      rdata    <= '0;
    end else begin
      if (we && addr == A_CTRL) begin
        en       <= wdata[0];
        act_high <= wdata[1];
        gate     <= wdata[2];
        if (!gate) code <= wdata[7:4];
      end
      if (we && addr == A_TIME) begin
        prd  <= wdata[2*CNT_W-1:CNT_W];
        duty <= wdata[CNT_W-1:0];
      end
      if (re) begin
        case (addr)
          A_CTRL:  rdata <= DATA_W'({code, 1'b0, gate, act_high, en});
          A_TIME:  rdata <= DATA_W'({prd, duty});
          default: rdata <= '0;
        endcase
      end
    end
  end

  p_code_held_r3: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_CTRL && gate) |=> $stable(code));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_W = pwm_pkg::DIV_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick
);
  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] div;

  always_comb div = pwm_pkg::div_of(code);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      tick <= 1'b0;
    end else if (pcnt >= div - DIV_W'(1)) begin
      pcnt <= '0;
      tick <= 1'b1;
    end else begin
      pcnt <= pcnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  p_no_tick_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick);
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    (run && tick && div > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             act_high,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sprd;
  logic [CNT_W-1:0] sduty;
  logic             wrap;

  always_comb wrap = tick && (cnt >= sprd);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sprd  <= '0;
      sduty <= '0;
      pwm   <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      sprd  <= prd;
      sduty <= duty;
      pwm   <= !act_high;
    end else begin
      if (wrap) begin
        cnt   <= '0;
        sprd  <= prd;
        sduty <= duty;
      end else if (tick) begin
        cnt <= cnt + CNT_W'(1);
      end
      pwm <= (cnt < sduty) ? act_high : !act_high;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt <= sprd);
  p_idle_rest_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0 && pwm == !$past(act_high)));
  p_zero_duty_r7: assert property (@(posedge clk) disable iff (rst)
    (run && sduty == '0) |=> pwm == !$past(act_high));
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> ($stable(sprd) && $stable(sduty)));
endmodule

// File: rtl/pwm_prescaled_channel.sv
module pwm_prescaled_channel #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_o
);
  logic             en, act_high, gate, run;
  logic [3:0]       code;
  logic [CNT_W-1:0] prd, duty;
  logic             tick;

  pwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .en(en), .act_high(act_high),
    .gate(gate), .code(code), .prd(prd), .duty(duty)
  );

  always_comb run = en && gate && (pwm_pkg::div_of(code) != '0);

  pwm_prescaler #(.DIV_W(pwm_pkg::DIV_W)) u_presc (
    .clk(clk), .rst(rst), .run(run), .code(code), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .act_high(act_high),
    .prd(prd), .duty(duty), .pwm(pwm_o)
  );

  p_gate_off_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!gate && $past(!gate)) |-> pwm_o == !$past(act_high));
endmodule

// File: tb/test_pwm_prescaled_channel.sv
module test_pwm_prescaled_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_o;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  pwm_prescaled_channel i_pwm_prescaled_channel (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  // waits for entry into the active level, then times both phases
  task automatic measure(input string req, input logic lvl, input int hi, input int lo);
    int a = 0, b = 0, t = 0;
    logic prev;
    @(negedge clk); prev = pwm_o;
    while (!(prev != lvl && pwm_o == lvl) && t < 4 * (hi + lo) + 50) begin
      prev = pwm_o; @(negedge clk); t++;
    end
    while (pwm_o == lvl && a < 2 * (hi + lo) + 10) begin a++; @(negedge clk); end
    while (pwm_o != lvl && b < 2 * (hi + lo) + 10) begin b++; @(negedge clk); end
    check({req, " active"}, a, hi);
    check({req, " inactive"}, b, lo);
  endtask

  task automatic hold_level(input string req, input logic lvl, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_o !== lvl) bad++; end
    check(req, bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pwm", pwm_o, 0);
    rd(2'd0, d); check("R1 ctrl", d, 32'h02);
    rd(2'd1, d); check("R1 time", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd1, 32'h1234_5678); rd(2'd1, d); check("R2 time rb", d, 32'h1234_5678);
    rd(2'd2, d); check("R2 unused addr", d, 0);
  endtask

  task automatic t_gate_rule();
    logic [31:0] d;
    wr(2'd0, 32'hF4); rd(2'd0, d); check("R3 code while off", d, 32'hF4);
    wr(2'd0, 32'h04); rd(2'd0, d); check("R3 code ignored gate on", d, 32'hF4);
    wr(2'd0, 32'h00); rd(2'd0, d); check("R3 gate turned off", d, 32'hF0);
    wr(2'd0, 32'h00); rd(2'd0, d); check("R3 code accepted", d, 32'h00);
  endtask

  task automatic t_basic();
    wr(2'd1, {16'd9, 16'd3});
    wr(2'd0, 32'hF2); wr(2'd0, 32'hF7);
    measure("R6 bypass P9 D3", 1'b1, 3, 7);
    wr(2'd1, {16'd4, 16'd2});
    measure("R6 P4 D2", 1'b1, 2, 3);
  endtask

  task automatic t_polarity();
    wr(2'd1, {16'd9, 16'd3});
    wr(2'd0, 32'hF5);
    measure("R8 inverted", 1'b0, 3, 7);
    wr(2'd0, 32'hF7);
    measure("R8 normal", 1'b1, 3, 7);
  endtask

  task automatic t_duty_edges();
    wr(2'd1, {16'd9, 16'd0});
    repeat (25) @(negedge clk);
    hold_level("R7 zero duty", 1'b0, 60);
    wr(2'd1, {16'd9, 16'd12});
    repeat (25) @(negedge clk);
    hold_level("R7 duty above period", 1'b1, 60);
  endtask

  task automatic t_update();
    int a = 0, t = 0;
    logic prev;
    wr(2'd1, {16'd9, 16'd3});
    repeat (25) @(negedge clk);
    prev = pwm_o;
    while (!(prev == 1'b0 && pwm_o == 1'b1) && t < 100) begin
      prev = pwm_o; @(negedge clk); t++;
    end
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = {16'd9, 16'd6};
    while (pwm_o == 1'b1 && a < 40) begin
      a++; @(negedge clk); bus_we = 1'b0;
    end
    check("R9 current pulse kept", a, 3);
    measure("R9 new width next cycle", 1'b1, 6, 4);
  endtask

  task automatic t_disable();
    wr(2'd1, {16'd9, 16'd3});
    wr(2'd0, 32'hF6);
    hold_level("R10 disabled", 1'b0, 30);
    @(negedge clk); bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'hF7;
    @(negedge clk); bus_we = 1'b0;
    @(negedge clk); check("R10 restart active", pwm_o, 1);
    wr(2'd0, 32'hF3);
    @(negedge clk);
    hold_level("R10 gate off", 1'b0, 30);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(2'd0, 32'h52); wr(2'd0, 32'h57);
    rd(2'd0, d); check("R5 reserved code held", d, 32'h57);
    hold_level("R5 reserved idle", 1'b0, 200);
    wr(2'd0, 32'hD2); wr(2'd0, 32'hD7);
    hold_level("R5 reserved 13", 1'b0, 100);
  endtask

  task automatic t_divider();
    wr(2'd0, 32'h02); wr(2'd1, {16'd1, 16'd1}); wr(2'd0, 32'h07);
    measure("R4 code0", 1'b1, 120, 120);
    wr(2'd0, 32'h03); wr(2'd0, 32'h12); wr(2'd0, 32'h17);
    measure("R4 code1", 1'b1, 180, 180);
    wr(2'd0, 32'h13); wr(2'd0, 32'h42); wr(2'd0, 32'h47);
    wr(2'd1, {16'd2, 16'd1});
    measure("R4 code4", 1'b1, 480, 960);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gate_rule();
    t_basic();
    t_polarity();
    t_duty_edges();
    t_update();
    t_disable();
    t_reserved();
    t_divider();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule